// File: doc/BRIEF.md
# Coin Credit Vend Controller

This block is a small synchronous controller for a single-slot coin acceptor that sells one item at a fixed price of fifteen cents. It accepts two kinds of coin, each signalled by a one-cycle pulse: a five-cent coin and a ten-cent coin. It keeps the credit collected so far in a two-bit state register. When that credit reaches the price, it raises a release strobe for one clock cycle. It never returns change. Paying too much lands in the same vend state as paying the exact amount.

Different coin orders that reach the same credit share one state, so the controller has only four credit states: 0, 5, 10 and 15 cents. After a vend the machine starts again from zero. If a coin arrives during the vend cycle, that coin opens the next sale. A parameter chooses between two output styles. In the registered style, release follows the fifteen-cent state. In the transition style, release is driven during the cycle whose coin completes the price. If both coin pulses arrive in the same cycle, the input is illegal: the credit is left untouched and a sticky fault flag is raised.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the credit returns to zero and `coin_err_o` clears, whatever the coin inputs are. Afterwards `release_o` is low until a full price is paid.
- R2: A pulse on `nickel_i` alone adds 5 cents and a pulse on `dime_i` alone adds 10 cents. Credit is held in the four states 0, 5, 10 and 15 cents.
- R3: From 10 cents, either coin alone moves the machine to the 15-cent state. The excess is kept and no change is given.
- R4: With `MEALY_OUT`=0, `release_o` is high for exactly the one cycle after the clock edge that brought credit to 15 cents, and low at every other time.
- R5: In the 15-cent state, a cycle with no coin returns the credit to zero. A nickel instead leads to 5 cents and a dime to 10 cents, so the coin starts the next sale.
- R6: Below 15 cents, a cycle with no coin leaves the credit unchanged.
- R7: When both coin inputs are high in one cycle, the credit is unchanged and `coin_err_o` goes high at the next edge. It stays high until reset.
- R8: With `MEALY_OUT`=1, `release_o` is high, with no clock delay, in any cycle where a single coin completes the price: a dime at 5 cents, or either coin at 10 cents. It is low in all other cycles, including the 15-cent state itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| release_o | output | 1 | Item release strobe |
| coin_err_o | output | 1 | Sticky flag for simultaneous coin pulses |

## Verification
The bench aims at the edges of the credit chain. A dime at 10 cents must not add a fifth state or wrap around; a wrong design would miss the vend or land at 5 cents. A coin that arrives in the vend cycle must start a new sale, and a design that ignored it would lose money. The bench also sends both coins at once: a faulty design would take one of them as credit or fail to keep the fault flag. It checks that the transition-style output fires in the completing cycle and not one cycle later. Finally, it drives reset with coins present, where a design that let the coins through would carry credit out of reset.

// File: rtl/vend_pkg.sv
// Package: shared types for the coin credit vend controller.
// Assumes a price of 15 cents built from 5-cent steps; the credit encoding
// is fixed so that the vend state is the only one with both bits set.
package vend_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_e;
endpackage

// File: rtl/vend_credit_step.sv
// Module: vend_credit_step
// Purely combinational next-credit logic. Applies one coin to the present
// credit, saturates at the price, treats the vend state as a fresh start,
// and flags simultaneous coins (credit held in that case).
// Assumes coin inputs are already synchronous single-cycle pulses.
module vend_credit_step
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_e nxt_o,
    output logic    dual_o
);
    logic [1:0] coin_sel;

    // Purpose: classify the coin pattern for this cycle.
    always_comb begin
        coin_sel = {dime_i, nickel_i};
        dual_o   = nickel_i & dime_i;
    end

    // Purpose: pick the next credit state from present credit and coin.
    always_comb begin
        nxt_o = cur_i;
        unique case (coin_sel)
            2'b01: begin
                unique case (cur_i)
                    CR_0:    nxt_o = CR_5;
                    CR_5:    nxt_o = CR_10;
                    CR_10:   nxt_o = CR_15;
                    default: nxt_o = CR_5;
                endcase
            end
            2'b10: begin
                unique case (cur_i)
                    CR_0:    nxt_o = CR_10;
                    CR_5:    nxt_o = CR_15;
                    CR_10:   nxt_o = CR_15;
                    default: nxt_o = CR_10;
                endcase
            end
            2'b00: begin
                nxt_o = (cur_i == CR_15) ? CR_0 : cur_i;
            end
            default: begin
                nxt_o = cur_i;
            end
        endcase
    end
endmodule

// File: rtl/vend_state_reg.sv
// Module: vend_state_reg
// Holds the credit state and the sticky coin-fault flag. Both clear on a
// synchronous active-low reset; the flag then only ever sets.
// Assumes the next-state input already encodes hold on illegal input.
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e nxt_i,
    input  logic    dual_i,
    output credit_e cur_o,
    output logic    err_o
);
    // Purpose: register the credit state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_o <= CR_0;
        end else begin
            cur_o <= nxt_i;
        end
    end

    // Purpose: latch a simultaneous-coin fault until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (dual_i) begin
            err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/vend_release_dec.sv
// Module: vend_release_dec
// Release output decoder. MEALY_OUT=0 decodes the vend state alone
// (both credit bits set); MEALY_OUT=1 flags the coin that completes the
// price in the same cycle. Assumes the encoding from vend_pkg.
module vend_release_dec
    import vend_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
) (
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output logic    release_o
);
    generate
        if (MEALY_OUT) begin : g_transition
            logic single_coin;
            // Purpose: raise release on the transition that reaches the price.
            always_comb begin
                single_coin = nickel_i ^ dime_i;
                release_o   = ((cur_i == CR_10) & single_coin)
                            | ((cur_i == CR_5) & dime_i & ~nickel_i);
            end
        end else begin : g_state
            logic [CREDIT_W-1:0] bits;
            // Purpose: raise release while in the vend state.
            always_comb begin
                bits      = cur_i;
                release_o = bits[1] & bits[0];
            end
        end
    endgenerate
endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl (top)
// Coin credit vend controller: five- and ten-cent pulses build credit to a
// fifteen-cent price, release strobes one item, no change is returned.
// Assumes single-cycle synchronous coin pulses and a synchronous reset.
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic release_o,
    output logic coin_err_o
);
    credit_e credit_q;
    credit_e credit_d;
    logic    dual_coin;

    vend_credit_step u_step (
        .cur_i    (credit_q),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .nxt_o    (credit_d),
        .dual_o   (dual_coin)
    );

    vend_state_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_i  (credit_d),
        .dual_i (dual_coin),
        .cur_o  (credit_q),
        .err_o  (coin_err_o)
    );

    vend_release_dec #(
        .MEALY_OUT (MEALY_OUT)
    ) u_rel (
        .cur_i     (credit_q),
        .nickel_i  (nickel_i),
        .dime_i    (dime_i),
        .release_o (release_o)
    );
endmodule

// File: rtl/vend_ctrl_chk.sv
// Module: vend_ctrl_chk
// Property checker bound into vend_ctrl. Observes ports and the credit
// register; assumes the credit encoding from vend_pkg.
module vend_ctrl_chk
    import vend_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
) (
    input logic    clk,
    input logic    rst_n,
    input logic    nickel_i,
    input logic    dime_i,
    input logic    release_o,
    input logic    coin_err_o,
    input credit_e credit_q
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (credit_q == CR_0) && !coin_err_o);

    assert_ten_reaches_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q == CR_10) && (nickel_i ^ dime_i) |=> credit_q == CR_15);

    assert_single_vend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);

    assert_full_idle_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q == CR_15) && !nickel_i && !dime_i |=> credit_q == CR_0);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q != CR_15) && !nickel_i && !dime_i |=> $stable(credit_q));

    assert_dual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nickel_i && dime_i |=> $stable(credit_q) && coin_err_o);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        coin_err_o |=> coin_err_o);

    generate
        if (MEALY_OUT) begin : g_trans_chk
            assert_quiet_in_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (credit_q == CR_15) |-> !release_o);
        end else begin : g_state_chk
            assert_release_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
                release_o |-> (credit_q == CR_15));
        end
    endgenerate
endmodule

bind vend_ctrl vend_ctrl_chk #(
    .MEALY_OUT (MEALY_OUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nickel_i   (nickel_i),
    .dime_i     (dime_i),
    .release_o  (release_o),
    .coin_err_o (coin_err_o),
    .credit_q   (credit_q)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel_s, err_s, rel_t, err_t;

    int checks = 0;
    int failures = 0;
    int credit = 0;
    bit err_m = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl #(.MEALY_OUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel_s), .coin_err_o(err_s)
    );

    vend_ctrl #(.MEALY_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .nickel_i(nickel), .dime_i(dime),
        .release_o(rel_t), .coin_err_o(err_t)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare before the edge, then advance the model.
    task automatic step(input bit n, input bit d, input bit rn, input string req);
        int add;
        bit exp_t;
        @(negedge clk);
        nickel = n;
        dime   = d;
        rst_n  = rn;
        #2;
        add = (n ? 5 : 0) + (d ? 10 : 0);
        exp_t = rn && !(n && d) && (credit < 15) && (add > 0) && (credit + add >= 15);
        if (rn) begin
            chk({req, " state-style release"}, int'(rel_s), int'(credit == 15));
            chk({req, " transition release R8"}, int'(rel_t), int'(exp_t));
            chk({req, " fault flag"}, int'(err_s), int'(err_m));
            chk({req, " fault flag (variant)"}, int'(err_t), int'(err_m));
        end
        @(posedge clk);
        if (!rn) begin
            credit = 0;
            err_m  = 1'b0;
        end else if (n && d) begin
            err_m = 1'b1;
        end else if (credit == 15) begin
            credit = add;
        end else if (credit + add > 15) begin
            credit = 15;
        end else begin
            credit = credit + add;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with coins present, then check the cleared state
        step(1, 0, 0, "R1");
        step(0, 1, 0, "R1");
        step(0, 0, 1, "R1 after reset");
        // R2 / R4: three nickels
        step(1, 0, 1, "R2");
        step(1, 0, 1, "R2");
        step(1, 0, 1, "R2 R4");
        step(0, 0, 1, "R4 R5");
        step(0, 0, 1, "R5");
        // R2 / R8: nickel then dime
        step(1, 0, 1, "R2");
        step(0, 1, 1, "R8");
        step(0, 0, 1, "R4");
        // R3: dime, nickel
        step(0, 1, 1, "R2");
        step(1, 0, 1, "R3");
        step(0, 0, 1, "R4");
        // R3: two dimes, overpay without change
        step(0, 1, 1, "R2");
        step(0, 1, 1, "R3");
        step(0, 0, 1, "R4");
        step(0, 0, 1, "R5");
        // R3: two nickels then a dime
        step(1, 0, 1, "R2");
        step(1, 0, 1, "R2");
        step(0, 1, 1, "R3");
        // R5: coin during the vend cycle starts a new sale
        step(1, 0, 1, "R5 nickel in vend");
        step(0, 0, 1, "R6");
        step(0, 1, 1, "R5");
        step(0, 1, 1, "R5 dime in vend");
        step(0, 0, 1, "R6");
        step(1, 0, 1, "R3");
        step(0, 0, 1, "R4");
        // R6: idle cycles between coins
        step(1, 0, 1, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 1, "R6");
        step(1, 0, 1, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R6");
        step(1, 0, 1, "R6");
        step(0, 0, 1, "R6");
        // R7: both coins at 5 cents, credit must stay at 5
        step(1, 0, 1, "R7");
        step(1, 1, 1, "R7");
        step(0, 0, 1, "R7 sticky");
        step(0, 1, 1, "R7 credit held");
        step(0, 0, 1, "R7");
        step(1, 1, 1, "R7 at zero");
        step(0, 1, 1, "R7");
        step(1, 0, 1, "R7");
        step(0, 0, 1, "R7 sticky");
        // R1: reset clears the fault
        step(0, 0, 0, "R1");
        step(0, 0, 1, "R1 fault cleared");
        step(0, 1, 1, "R2");
        step(0, 1, 1, "R8");
        step(0, 0, 1, "R4");
        step(0, 0, 1, "R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule